// File: doc/BRIEF.md
# Execute Packet Dispatcher

This block sits between program memory and the functional units of a wide-issue core. Program memory returns one fetch packet at a time. A fetch packet is 256 bits wide and holds eight 32-bit instruction words. The dispatcher cuts each fetch packet into execute packets. Bit 0 of every word is a link flag: when it is 1, the next word joins the same group; when it is 0, the group ends there. One execute packet goes out per clock. It appears left-aligned on eight slot outputs, and each slot has its own valid flag.

A new fetch packet is requested only once the packet being held has reached its final execute packet. The request can therefore overlap the issue of that final group, which keeps dispatch gap-free. A single spare buffer absorbs a delivery that arrives while downstream is stalled. A downstream stall freezes both the outputs and the dispatch position. A group is never carried across two fetch packets. If the last word of a packet still has its link flag set, the group is closed there anyway and a one-cycle error pulse is raised.

Top module: `vliw_dispatch`

## Requirements
- R1: While reset is low and right after it, every slot valid flag is 0, the error flag is 0 and the fetch request is 1.
- R2: Words are consumed from bits 31:0 upward. An execute packet ends at the first word whose bit 0 is 0. Output slot k carries the k-th word of the group. Valid flags are contiguous from slot 0. Slots past the group have valid 0 and all-zero instruction.
- R3: Without stall, execute packets are issued on consecutive cycles, one per cycle. A fetch packet of eight single-word groups that is followed by another fetch packet produces eight consecutive cycles with exactly slot 0 valid, with no gap in between.
- R4: The fetch request is 1 only when no spare packet is held and the current packet is either absent or on its last execute packet. A delivery counts only in a cycle where request and valid are both 1. A packet handed over on one clock edge has its first group on the outputs after the next edge, or later if the block is stalled or still issuing.
- R5: A group never spans two fetch packets. Word 7 always closes its group, and the following fetch packet starts again at its own word 0.
- R6: When an issued group ends at word 7 and that word has bit 0 set, the error flag is 1 during the first cycle the group is on the outputs. Otherwise the flag is 0.
- R7: While stall is 1, the slot outputs and the dispatch position hold their values and no group is lost. The error flag drops to 0 during a stall.
- R8: Reset discards both the current and the spare fetch packet. After reset, nothing is issued until a new delivery arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_o | output | 1 | Request for the next fetch packet |
| fetch_valid_i | input | 1 | Memory presents a fetch packet |
| fetch_data_i | input | 256 | Fetch packet, word 0 in bits 31:0 |
| stall_i | input | 1 | Downstream not ready; freezes dispatch |
| slot_instr_o | output | 256 | Slot k instruction in bits 32k+31:32k |
| slot_valid_o | output | 8 | Per-slot valid flags |
| chain_err_o | output | 1 | Pulse: packet ended on a linked final word |

## Verification
Four stimulus patterns are used. Packets with mixed link flags exercise group splitting at arbitrary positions. Packets made only of single-word groups expose any bubble at the boundary between fetch packets. Packets forming one eight-word group show that the request goes up on the very first issue cycle. Packets whose last word is linked separate a correct forced end, with the error pulse, from a group that wrongly spills into the next packet. Intermittent delivery, periodic stalls and a reset with both buffers full show whether the request gating, the stall hold and the discard are each handled on their own.

// File: rtl/vliw_dispatch_pkg.sv
package vliw_dispatch_pkg;
  localparam int unsigned DISP_SLOTS = 8;
  localparam int unsigned DISP_IW    = 32;
endpackage

// File: rtl/vliw_ep_scan.sv
// Finds the execute packet that starts at ptr_i and left-aligns it.
module vliw_ep_scan #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IW    = 32,
  localparam int unsigned PW   = $clog2(SLOTS)
) (
  input  logic [SLOTS*IW-1:0] pkt_i,
  input  logic [PW-1:0]       ptr_i,
  output logic [SLOTS-1:0]    member_o,
  output logic [SLOTS*IW-1:0] instr_o,
  output logic [PW-1:0]       next_ptr_o,
  output logic                last_o,
  output logic                chain_err_o
);
  always_comb begin
    logic run;
    int   src;
    int   endp;
    run      = 1'b1;
    endp     = int'(ptr_i);
    member_o = '0;
    instr_o  = '0;
    for (int k = 0; k < SLOTS; k++) begin
      src = int'(ptr_i) + k;
      if (run && src < SLOTS) begin
        member_o[k]          = 1'b1;
        instr_o[k*IW +: IW]  = pkt_i[src*IW +: IW];
        endp                 = src;
        run                  = pkt_i[src*IW];
      end else begin
        run = 1'b0;
      end
    end
    last_o      = (endp == SLOTS - 1);
    chain_err_o = last_o && pkt_i[(SLOTS-1)*IW];
    next_ptr_o  = last_o ? '0 : PW'(endp + 1);
  end
endmodule

// File: rtl/vliw_fetch_buf.sv
// Current fetch packet plus one spare, with request gating.
module vliw_fetch_buf #(
  parameter int unsigned PKT_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_valid_i,
  input  logic [PKT_W-1:0] fetch_data_i,
  input  logic             last_ep_i,
  input  logic             retire_i,
  output logic             fetch_req_o,
  output logic             cur_valid_o,
  output logic [PKT_W-1:0] cur_data_o
);
  logic             spare_q;
  logic [PKT_W-1:0] spare_d_q;
  logic             take;
  logic             cur_free;

  assign fetch_req_o = !spare_q && (!cur_valid_o || last_ep_i);
  assign take        = fetch_req_o && fetch_valid_i;
  assign cur_free    = !cur_valid_o || retire_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_valid_o <= 1'b0;
      cur_data_o  <= '0;
      spare_q     <= 1'b0;
      spare_d_q   <= '0;
    end else if (cur_free) begin
      if (spare_q) begin
        cur_data_o  <= spare_d_q;
        cur_valid_o <= 1'b1;
        spare_q     <= 1'b0;
      end else if (take) begin
        cur_data_o  <= fetch_data_i;
        cur_valid_o <= 1'b1;
      end else begin
        cur_valid_o <= 1'b0;
      end
    end else if (take) begin
      spare_d_q <= fetch_data_i;
      spare_q   <= 1'b1;
    end
  end

  assert_take_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_valid_i) |=> cur_valid_o);
  assert_spare_feeds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spare_q |=> cur_valid_o);
  assert_req_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_valid_o && !spare_q) |-> fetch_req_o);
endmodule

// File: rtl/vliw_slot_out.sv
// Registered slot outputs, held under stall.
module vliw_slot_out #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stall_i,
  input  logic                issue_i,
  input  logic [SLOTS-1:0]    member_i,
  input  logic [SLOTS*IW-1:0] instr_i,
  input  logic                err_i,
  output logic [SLOTS*IW-1:0] slot_instr_o,
  output logic [SLOTS-1:0]    slot_valid_o,
  output logic                chain_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_instr_o <= '0;
      slot_valid_o <= '0;
      chain_err_o  <= 1'b0;
    end else if (!stall_i) begin
      slot_valid_o <= issue_i ? member_i : '0;
      slot_instr_o <= issue_i ? instr_i : '0;
      chain_err_o  <= issue_i && err_i;
    end else begin
      chain_err_o  <= 1'b0;
    end
  end

  logic tail_link;
  always_comb begin
    tail_link = 1'b0;
    for (int k = 0; k < SLOTS; k++)
      if (slot_valid_o[k]) tail_link = slot_instr_o[k*IW];
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(slot_valid_o) && $stable(slot_instr_o)));
  assert_thermo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_o & (slot_valid_o + SLOTS'(1))) == '0);
  assert_err_tail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_err_o |-> (slot_valid_o[0] && tail_link));

  for (genvar k = 0; k < SLOTS; k++) begin : g_chk
    assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_valid_o[k] |-> (slot_instr_o[k*IW +: IW] == '0));
    if (k < SLOTS - 1) begin : g_link
      assert_link_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_valid_o[k+1] |-> slot_instr_o[k*IW]);
    end
  end
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch #(
  parameter int unsigned SLOTS = vliw_dispatch_pkg::DISP_SLOTS,
  parameter int unsigned IW    = vliw_dispatch_pkg::DISP_IW,
  localparam int unsigned PW   = $clog2(SLOTS),
  localparam int unsigned PKT_W = SLOTS * IW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             fetch_req_o,
  input  logic             fetch_valid_i,
  input  logic [PKT_W-1:0] fetch_data_i,
  input  logic             stall_i,
  output logic [PKT_W-1:0] slot_instr_o,
  output logic [SLOTS-1:0] slot_valid_o,
  output logic             chain_err_o
);
  logic             cur_valid;
  logic [PKT_W-1:0] cur_data;
  logic [PW-1:0]    ptr_q;
  logic [PW-1:0]    next_ptr;
  logic [SLOTS-1:0] member;
  logic [PKT_W-1:0] aligned;
  logic             last_ep;
  logic             ep_err;
  logic             issue;
  logic             retire;

  assign issue  = cur_valid && !stall_i;
  assign retire = issue && last_ep;

  vliw_fetch_buf #(.PKT_W(PKT_W)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_valid_i(fetch_valid_i),
    .fetch_data_i (fetch_data_i),
    .last_ep_i    (last_ep),
    .retire_i     (retire),
    .fetch_req_o  (fetch_req_o),
    .cur_valid_o  (cur_valid),
    .cur_data_o   (cur_data)
  );

  vliw_ep_scan #(.SLOTS(SLOTS), .IW(IW)) u_scan (
    .pkt_i      (cur_data),
    .ptr_i      (ptr_q),
    .member_o   (member),
    .instr_o    (aligned),
    .next_ptr_o (next_ptr),
    .last_o     (last_ep),
    .chain_err_o(ep_err)
  );

  // ptr wraps to 0 when the last group retires, ready for the next packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (issue) ptr_q <= next_ptr;
  end

  vliw_slot_out #(.SLOTS(SLOTS), .IW(IW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .issue_i     (issue),
    .member_i    (member),
    .instr_i     (aligned),
    .err_i       (ep_err),
    .slot_instr_o(slot_instr_o),
    .slot_valid_o(slot_valid_o),
    .chain_err_o (chain_err_o)
  );

  assert_ptr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(ptr_q));
  assert_one_ep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid && !stall_i) |=> slot_valid_o[0]);
  assert_ptr_new_pkt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire |=> (ptr_q == '0));
endmodule

// File: tb/vliw_dispatch_test.sv
`timescale 1ns/1ps
module vliw_dispatch_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fv = 1'b0;
  logic         stall = 1'b0;
  logic [255:0] fdata = '0;
  logic         req;
  logic [255:0] s_instr;
  logic [7:0]   s_valid;
  logic         err;

  always #2 clk = ~clk;

  vliw_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_req_o(req), .fetch_valid_i(fv),
    .fetch_data_i(fdata), .stall_i(stall), .slot_instr_o(s_instr),
    .slot_valid_o(s_valid), .chain_err_o(err)
  );

  typedef struct packed {
    logic         e;
    logic [7:0]   v;
    logic [255:0] ins;
  } grp_t;

  grp_t         q[$];
  bit           spare_has;
  logic [255:0] spare_d;
  grp_t         exp_o;
  int           pkt_n = 0;
  int           mode = 0;
  int           checks = 0;
  int           errors = 0;
  string        tag = "R1";
  bit           done = 0;

  function automatic logic [255:0] gen(int n, int m);
    logic [255:0] p;
    logic [31:0]  h;
    for (int i = 0; i < 8; i++) begin
      h = 32'(n) * 32'd2654435761 + 32'(i) * 32'd40503 + 32'd12345;
      h = h ^ (h >> 13);
      h = h * 32'd1103515245;
      case (m)
        1: h[0] = 1'b0;
        2: h[0] = (i < 7);
        3: h[0] = (i == 7) ? 1'b1 : h[9];
        default: h[0] = h[11];
      endcase
      p[i*32 +: 32] = h;
    end
    return p;
  endfunction

  function automatic void load(logic [255:0] p);
    grp_t g;
    int   k;
    g = '0;
    k = 0;
    q.delete();
    for (int i = 0; i < 8; i++) begin
      g.ins[k*32 +: 32] = p[i*32 +: 32];
      g.v[k] = 1'b1;
      k++;
      if (!p[i*32] || i == 7) begin
        g.e = (i == 7) && p[i*32];
        q.push_back(g);
        g = '0;
        k = 0;
      end
    end
  endfunction

  function automatic bit req_exp();
    return !spare_has && q.size() <= 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      spare_has = 0;
      exp_o = '0;
    end else begin
      bit acc, had, ret;
      acc = req_exp() && fv;
      had = q.size() > 0;
      ret = 0;
      if (!stall) begin
        if (had) begin
          exp_o = q.pop_front();
          ret = (q.size() == 0);
        end else exp_o = '0;
      end else exp_o.e = 1'b0;
      if (!had || ret) begin
        if (spare_has) begin load(spare_d); spare_has = 0; end
        else if (acc) load(fdata);
      end else if (acc) begin
        spare_d = fdata;
        spare_has = 1;
      end
      if (acc) pkt_n++;
    end
  end

  task automatic compare();
    checks++;
    if (s_valid !== exp_o.v || s_instr !== exp_o.ins) begin
      errors++;
      $display("FAIL %s slots: valid=%h instr=%h expected valid=%h instr=%h",
               (tag == "R6") ? "R2" : tag, s_valid, s_instr, exp_o.v, exp_o.ins);
    end
    checks++;
    if (err !== exp_o.e) begin
      errors++;
      $display("FAIL R6 error flag: got %b expected %b", err, exp_o.e);
    end
    checks++;
    if (req !== req_exp()) begin
      errors++;
      $display("FAIL R4 fetch request: got %b expected %b", req, req_exp());
    end
  endtask

  task automatic step(input bit v, input bit s);
    @(negedge clk);
    if (rst_n) compare();
    fv = v;
    stall = s;
    fdata = gen(pkt_n, mode);
  endtask

  task automatic run(input string t, input int m, input int cycles, input int fv_pat, input int st_pat);
    tag = t;
    mode = m;
    for (int c = 0; c < cycles; c++)
      step(fv_pat == 0 ? 1'b1 : ((c % fv_pat) != 0), st_pat == 0 ? 1'b0 : ((c % st_pat) == 1));
  endtask

  task automatic drain();
    for (int c = 0; c < 12; c++) step(1'b0, 1'b0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (s_valid !== 8'h00 || err !== 1'b0 || req !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: valid=%h err=%b req=%b expected 00 0 1", s_valid, err, req);
    end
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    checks++;
    if (s_valid !== 8'h00 || req !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset: valid=%h req=%b expected 00 1", s_valid, req);
    end

    run("R2", 0, 80, 0, 0);
    drain();

    // R3: single-word groups back to back must give one slot-0 issue every cycle
    tag = "R3";
    mode = 1;
    for (int c = 0; c < 40; c++) begin
      step(1'b1, 1'b0);
      if (c >= 4) begin
        checks++;
        if (s_valid !== 8'h01) begin
          errors++;
          $display("FAIL R3 throughput at cycle %0d: valid=%h expected 01", c, s_valid);
        end
      end
    end
    drain();

    run("R4", 2, 60, 4, 0);
    drain();
    run("R4", 0, 60, 3, 0);
    drain();
    run("R5", 3, 60, 0, 0);
    drain();
    run("R6", 3, 60, 2, 4);
    drain();
    run("R7", 0, 120, 0, 3);
    drain();
    run("R7", 2, 60, 0, 2);
    drain();

    // R8: fill current and spare under stall, then reset
    tag = "R8";
    mode = 2;
    for (int c = 0; c < 4; c++) step(1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    fv = 1'b0;
    stall = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 6; c++) begin
      step(1'b0, 1'b0);
      checks++;
      if (s_valid !== 8'h00 || err !== 1'b0) begin
        errors++;
        $display("FAIL R8 after reset discard: valid=%h err=%b expected 00 0", s_valid, err);
      end
    end
    run("R8", 0, 20, 0, 0);
    drain();

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule